// File: doc/BRIEF.md
# ECP Extended Control and Byte FIFO

This block provides the extended control register, the byte FIFO and the two capability registers of a parallel port that supports ECP. A host reaches all of them over a byte-wide register bus with four addresses. The top three bits of the extended control register choose the port mode. Its two lowest bits report whether the FIFO is empty or full. Bit 2 is a service flag that the hardware raises when the FIFO level crosses a programmed threshold. The direction of the crossing that counts depends on the data-direction bit of the control register.

The block has no parallel-cable handshake engines. The only way bytes enter or leave the FIFO is through the host, in the FIFO test mode. This lets probing software measure the FIFO depth and both service thresholds with no peripheral attached. Configuration mode replaces the FIFO address with a read-only capability byte and exposes a second capability byte at the next address. Selecting the plain compatibility mode flushes the FIFO.

Register addresses: 0 is the control register, 1 is the FIFO (or capability A in configuration mode), 2 is capability B, and 3 is the extended control register. Reads are combinational from the current state. A FIFO read pops at the clock edge that ends the access.

Top module: `ecp_xctl`

## Requirements
- R1: After reset the extended control register reads 0x05 (mode 000, bits 4:3 zero, service flag 1, FIFO empty). The control register reads 0x00, port_mode is 000, svc_flag is 1 and dir_rev is 0.
- R2: A write to address 3 stores bits 7:5 as the mode and bits 4:3 as plain storage, and both read back unchanged. port_mode follows bits 7:5. The mode codes are 000 compatibility, 001 bidirectional, 110 FIFO test and 111 configuration.
- R3: Bit 0 of address 3 reads 1 exactly when the FIFO is empty, and bit 1 reads 1 exactly when it is full. Writes to these two bits have no effect, so writing 0x34 with an empty FIFO reads back 0x35.
- R4: A write to address 3 with mode 000 empties the FIFO. A change to any other mode keeps its contents.
- R5: In FIFO test mode, writes to address 1 push bytes until the FIFO is full, and further writes are dropped. Reads of address 1 return the bytes in the order they were written and pop them. A read with the FIFO empty changes nothing.
- R6: Outside FIFO test mode, writes to address 1 leave the FIFO unchanged. Outside configuration mode, reads of address 1 return 0x00.
- R7: Address 0 holds an 8-bit read/write control register, and its bit 5 drives dir_rev (1 means reverse direction).
- R8: With dir_rev at 0, a pop that brings the free space to exactly WR_THRESH sets the service flag (bit 2 of address 3).
- R9: With dir_rev at 1, a push that brings the occupancy to exactly RD_THRESH sets the service flag.
- R10: Writing bit 2 of address 3 loads the service flag with the written value. A flag cleared this way stays 0 until a new threshold crossing.
- R11: In configuration mode, address 1 reads {LEVEL_IRQ, PWORD_CODE, 4'b0000} (PWORD_CODE 001 means 8-bit words) and address 2 reads {2'b00, IRQ_SEL, DMA_SEL} (DMA_SEL 000 means no channel). In all other modes address 2 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (pops the FIFO in test mode) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| port_mode | output | 3 | Current mode field |
| dir_rev | output | 1 | Reverse data direction |
| svc_flag | output | 1 | Service flag |

## Verification
The assertions check the following on every cycle:
- The FIFO never reports empty and full together.
- A push into a full FIFO or a pop from an empty one leaves the occupancy unchanged.
- A compatibility-mode write empties the FIFO.
- FIFO-address writes outside test mode change nothing.
- The mode output follows each extended control write.
- A written zero clears the service flag, and the flag holds when there is no access.

Only the bench's scenarios show the following:
- Data ordering through the FIFO.
- The exact pop or push at which each threshold fires, in both directions.
- The capability byte values.
- The fixed readback of 0x35 after writing 0x34.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

    localparam logic [2:0] MODE_SPP       = 3'b000;
    localparam logic [2:0] MODE_BIDIR     = 3'b001;
    localparam logic [2:0] MODE_FIFO_TEST = 3'b110;
    localparam logic [2:0] MODE_CONFIG    = 3'b111;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_FIFO = 2'd1,
        SEL_CAPB = 2'd2,
        SEL_XCTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [2:0] mode;
        logic [1:0] spare;
        logic       svc;
    } xctl_t;

    localparam xctl_t XCTL_RESET = '{mode: MODE_SPP, spare: 2'b00, svc: 1'b1};

    function automatic logic [7:0] pack_xctl(xctl_t s, logic full, logic empty);
        return {s.mode, s.spare, s.svc, full, empty};
    endfunction

    function automatic logic [7:0] make_capa(logic level, logic [2:0] pword);
        return {level, pword, 4'b0000};
    endfunction

    function automatic logic [7:0] make_capb(logic [2:0] irq, logic [2:0] dma);
        return {2'b00, irq, dma};
    endfunction

endpackage

// File: rtl/ecp_fifo.sv
module ecp_fifo #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [7:0]    din,
    output logic [7:0]    dout,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_EMPTY_FULL_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({empty, full}));                                         // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !flush && full) |=> (count == $past(count)));    // R5
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && !flush && empty) |=> (count == $past(count)));   // R5

endmodule

// File: rtl/ecp_svc_flag.sv
module ecp_svc_flag #(
    parameter int DEPTH     = 16,
    parameter int WR_THRESH = 4,
    parameter int RD_THRESH = 12,
    parameter int CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          load_val,
    input  logic          reverse,
    input  logic          pushed,
    input  logic          popped,
    input  logic [CW-1:0] count,
    output logic          flag
);
    localparam logic [CW-1:0] FWD_AT = CW'(DEPTH - WR_THRESH + 1);
    localparam logic [CW-1:0] REV_AT = CW'(RD_THRESH - 1);

    logic fwd_cross, rev_cross;

    assign fwd_cross = !reverse && popped && (count == FWD_AT);
    assign rev_cross =  reverse && pushed && (count == REV_AT);

    always_ff @(posedge clk) begin
        if (rst)                        flag <= 1'b1;
        else if (load)                  flag <= load_val;
        else if (fwd_cross || rev_cross) flag <= 1'b1;
    end

    AST_SVC_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (load && !load_val) |=> !flag);                                   // R10
    AST_SVC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!load && !pushed && !popped) |=> $stable(flag));                 // R10

endmodule

// File: rtl/ecp_xctl.sv
module ecp_xctl
    import ecp_pkg::*;
#(
    parameter int         DEPTH      = 16,
    parameter int         WR_THRESH  = 4,
    parameter int         RD_THRESH  = 12,
    parameter logic [2:0] PWORD_CODE = 3'b001,
    parameter logic       LEVEL_IRQ  = 1'b1,
    parameter logic [2:0] IRQ_SEL    = 3'b101,
    parameter logic [2:0] DMA_SEL    = 3'b011
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic [2:0] port_mode,
    output logic       dir_rev,
    output logic       svc_flag
);
    localparam int         CW   = $clog2(DEPTH + 1);
    localparam logic [7:0] CAPA = make_capa(LEVEL_IRQ, PWORD_CODE);
    localparam logic [7:0] CAPB = make_capb(IRQ_SEL, DMA_SEL);

    reg_sel_e      sel;
    logic [7:0]    ctrl_q;
    xctl_t         xctl_q;
    logic          in_test, in_cfg, xctl_wr;
    logic          fifo_push, fifo_pop, fifo_flush;
    logic [7:0]    fifo_dout;
    logic [CW-1:0] fifo_count;
    logic          fifo_empty, fifo_full;

    assign sel        = reg_sel_e'(reg_addr);
    assign in_test    = (xctl_q.mode == MODE_FIFO_TEST);
    assign in_cfg     = (xctl_q.mode == MODE_CONFIG);
    assign xctl_wr    = reg_wr && (sel == SEL_XCTL);
    assign fifo_push  = reg_wr && (sel == SEL_FIFO) && in_test;
    assign fifo_pop   = reg_rd && (sel == SEL_FIFO) && in_test;
    assign fifo_flush = xctl_wr && (reg_wdata[7:5] == MODE_SPP);

    assign port_mode = xctl_q.mode;
    assign dir_rev   = ctrl_q[5];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q       <= 8'h00;
            xctl_q.mode  <= XCTL_RESET.mode;
            xctl_q.spare <= XCTL_RESET.spare;
        end else begin
            if (reg_wr && (sel == SEL_CTRL)) ctrl_q <= reg_wdata;
            if (xctl_wr) begin
                xctl_q.mode  <= reg_wdata[7:5];
                xctl_q.spare <= reg_wdata[4:3];
            end
        end
    end

    ecp_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .flush (fifo_flush),
        .push  (fifo_push),
        .pop   (fifo_pop),
        .din   (reg_wdata),
        .dout  (fifo_dout),
        .count (fifo_count),
        .empty (fifo_empty),
        .full  (fifo_full)
    );

    ecp_svc_flag #(
        .DEPTH(DEPTH), .WR_THRESH(WR_THRESH), .RD_THRESH(RD_THRESH), .CW(CW)
    ) u_svc (
        .clk      (clk),
        .rst      (rst),
        .load     (xctl_wr),
        .load_val (reg_wdata[2]),
        .reverse  (dir_rev),
        .pushed   (fifo_push && !fifo_full),
        .popped   (fifo_pop && !fifo_empty),
        .count    (fifo_count),
        .flag     (xctl_q.svc)
    );

    assign svc_flag = xctl_q.svc;

    always_comb begin
        unique case (sel)
            SEL_CTRL: reg_rdata = ctrl_q;
            SEL_FIFO: reg_rdata = in_cfg ? CAPA : (in_test ? fifo_dout : 8'h00);
            SEL_CAPB: reg_rdata = in_cfg ? CAPB : 8'h00;
            default:  reg_rdata = pack_xctl(xctl_q, fifo_full, fifo_empty);
        endcase
    end

    AST_SPP_FLUSH: assert property (@(posedge clk) disable iff (rst)
        fifo_flush |=> fifo_empty);                                       // R4
    AST_FIFO_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && (sel == SEL_FIFO) && !in_test) |=> $stable(fifo_count)); // R6
    AST_MODE_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        xctl_wr |=> (port_mode == $past(reg_wdata[7:5])));                // R2

endmodule

// File: tb/ecp_xctl_test.sv
module ecp_xctl_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [2:0] port_mode;
    logic       dir_rev;
    logic       svc_flag;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ecp_xctl uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .port_mode(port_mode), .dir_rev(dir_rev), .svc_flag(svc_flag)
    );

    // vector: wr, rd, addr[1:0], wdata[7:0], check, expect[7:0], req[3:0]
    function automatic logic [24:0] vw(logic [1:0] a, logic [7:0] d);
        return {1'b1, 1'b0, a, d, 1'b0, 8'h00, 4'd0};
    endfunction
    function automatic logic [24:0] vr(logic [1:0] a, logic [7:0] e, logic [3:0] q);
        return {1'b0, 1'b1, a, 8'h00, 1'b1, e, q};
    endfunction

    localparam int NV = 33;
    localparam logic [24:0] VEC [NV] = '{
        vr(2'd3, 8'h05, 4'd1),                  // R1 reset value
        vr(2'd0, 8'h00, 4'd1),                  // R1
        vr(2'd1, 8'h00, 4'd6),                  // R6 reads 0 outside config
        vw(2'd3, 8'h34), vr(2'd3, 8'h35, 4'd3), // R3 fixed readback
        vw(2'd3, 8'hFB), vr(2'd3, 8'hF9, 4'd2), // R2 status bits not writable
        vr(2'd1, 8'h90, 4'd11),                 // R11 capability A
        vr(2'd2, 8'h2B, 4'd11),                 // R11 capability B
        vw(2'd1, 8'h77), vr(2'd3, 8'hF9, 4'd6), // R6 config write ignored
        vw(2'd3, 8'hC0), vr(2'd3, 8'hC1, 4'd2), // R2 test mode
        vr(2'd2, 8'h00, 4'd11),                 // R11 cap B hidden
        vw(2'd1, 8'h11), vw(2'd1, 8'h22),
        vr(2'd3, 8'hC0, 4'd3),                  // R3 not empty
        vr(2'd1, 8'h11, 4'd5),                  // R5 order
        vr(2'd1, 8'h22, 4'd5),                  // R5
        vr(2'd3, 8'hC1, 4'd3),                  // R3 empty again
        vw(2'd0, 8'hA5), vr(2'd0, 8'hA5, 4'd7), // R7
        vw(2'd0, 8'h0C), vr(2'd0, 8'h0C, 4'd7), // R7
        vw(2'd1, 8'h33), vw(2'd3, 8'h20),
        vr(2'd3, 8'h20, 4'd4),                  // R4 no flush in mode 001
        vw(2'd1, 8'h44), vr(2'd1, 8'h00, 4'd6), // R6
        vw(2'd3, 8'h00), vr(2'd3, 8'h01, 4'd4), // R4 flush
        vw(2'd3, 8'hC0), vr(2'd3, 8'hC1, 4'd4)  // R4 still empty
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic r, input logic [1:0] a,
                          input logic [7:0] d, output logic [7:0] q);
        @(negedge clk);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        #2 q = reg_rdata;
        @(posedge clk);
        #1 reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        do_reset();
        chk("R1 port_mode", {5'b0, port_mode}, 8'h00);
        chk("R1 svc_flag", {7'b0, svc_flag}, 8'h01);
        chk("R1 dir_rev", {7'b0, dir_rev}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][24], VEC[i][23], VEC[i][22:21], VEC[i][20:13], q);
            if (VEC[i][12]) chk($sformatf("R%0d vec %0d", VEC[i][3:0], i), q, VEC[i][11:4]);
        end
        chk("R2 port_mode", {5'b0, port_mode}, 8'h06);

        // R8 forward threshold while draining a full FIFO
        access(1, 0, 2'd0, 8'h0C, q);
        access(1, 0, 2'd3, 8'hC4, q);
        access(1, 0, 2'd3, 8'hC0, q);
        chk("R10 cleared", {7'b0, svc_flag}, 8'h00);
        for (int k = 0; k < 16; k++) access(1, 0, 2'd1, 8'(k * 3 + 1), q);
        access(0, 1, 2'd3, 8'h00, q);
        chk("R3 full", q, 8'hC2);
        access(1, 0, 2'd1, 8'hEE, q);          // R5 dropped when full
        for (int k = 0; k < 16; k++) begin
            access(0, 1, 2'd1, 8'h00, q);
            chk("R5 drain order", q, 8'(k * 3 + 1));
            chk("R8 forward flag", {7'b0, svc_flag}, {7'b0, k >= 3});
        end
        access(0, 1, 2'd3, 8'h00, q);
        chk("R8 status", q, 8'hC5);
        access(0, 1, 2'd1, 8'h00, q);          // R5 pop while empty
        access(0, 1, 2'd3, 8'h00, q);
        chk("R5 empty pop", q, 8'hC5);
        access(1, 0, 2'd3, 8'hC0, q);
        access(1, 0, 2'd1, 8'h5A, q);
        access(0, 1, 2'd1, 8'h00, q);
        chk("R5 after empty pop", q, 8'h5A);
        chk("R10 stays clear", {7'b0, svc_flag}, 8'h00);
        access(1, 0, 2'd3, 8'hC4, q);
        chk("R10 write one", {7'b0, svc_flag}, 8'h01);

        // R9 reverse threshold while filling
        access(1, 0, 2'd0, 8'h2C, q);
        chk("R7 dir_rev", {7'b0, dir_rev}, 8'h01);
        access(1, 0, 2'd3, 8'h00, q);
        access(1, 0, 2'd3, 8'hC0, q);
        for (int k = 0; k < 16; k++) begin
            access(1, 0, 2'd1, 8'(k + 8'h80), q);
            chk("R9 reverse flag", {7'b0, svc_flag}, {7'b0, k >= 11});
        end
        access(1, 0, 2'd3, 8'hC0, q);
        for (int k = 0; k < 16; k++) access(0, 1, 2'd1, 8'h00, q);
        chk("R10 no crossing on drain", {7'b0, svc_flag}, 8'h00);
        access(0, 1, 2'd3, 8'h00, q);
        chk("R9 drained", q, 8'hC1);

        // R1 reset with contents
        access(1, 0, 2'd1, 8'h99, q);
        do_reset();
        access(0, 1, 2'd3, 8'h00, q);
        chk("R1 after reset", q, 8'h05);
        access(0, 1, 2'd0, 8'h00, q);
        chk("R1 ctrl after reset", q, 8'h00);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule